// File: doc/BRIEF.md
# Virtual wire handshake responder

This block answers system-event virtual wires on the peripheral side of an eSPI link without software help. It watches three warning wires that the master drives (host reset warning, out-of-band reset warning, suspend warning) and raises the matching acknowledge wire on its own. It also drives the boot-load done and boot-load status wires, tracks the platform reset wire, and holds an out-of-band channel-ready flag.

Its inputs are wire levels that an upstream decoder has already extracted from master packets, plus a one-cycle pulse that marks a decoded system-event update and a one-cycle link hardware-reset pulse. Its outputs are the outgoing wire vector, with a change strobe that a transmit queue can use to send one message, and the tracked platform reset level with a valid flag and a change pulse. Packet framing, CRC and the serial physical layer belong to other blocks.

The synchronous active-low reset stands for a full power loss. The link reset only restarts the link. After either one, a boot-acknowledge pass runs once.

Top module: `vw_sysevt_responder`

## Requirements
- R1: While `rst_n` is low, `out_wires`, `out_strobe`, `oob_ready`, `plt_valid` and `plt_chg` are all zero.
- R2: On the first clock edge after reset release, boot-load done (`out_wires[0]`) and boot-load status (`out_wires[1]`) rise together, so `out_wires` reads 5'b00011 in the cycle after that edge. The two bits are always equal.
- R3: Boot-load done, once set, stays set until `rst_n` goes low. A link reset does not clear it.
- R4: A rising edge on host reset warning (`warn_in[0]`) sets host reset acknowledge (`out_wires[2]`) in the cycle after the edge.
- R5: A rising edge on out-of-band reset warning (`warn_in[1]`) sets out-of-band reset acknowledge (`out_wires[3]`) in the cycle after the edge.
- R6: A rising edge on suspend warning (`warn_in[2]`) sets suspend acknowledge (`out_wires[4]`) in the cycle after the edge.
- R7: Each acknowledge stays high while its warning is high. It goes low in the cycle after the warning is sampled low.
- R8: A link reset pulse sets `oob_ready` and clears all acknowledge wires in the cycle after the pulse. On the edge after that, a boot pass sets suspend acknowledge if suspend warning is high, with no edge needed. Host and out-of-band acknowledges stay low until their warnings rise again.
- R9: `plt_valid` stays low until the first `sysevt_upd` pulse or a change on `plt_rst_in`. Every such recording copies `plt_rst_in` into `plt_level` and pulses `plt_chg` for one cycle. Later changes of `plt_rst_in` are recorded the same way.
- R10: `out_strobe` is high for exactly one cycle, the first cycle in which `out_wires` shows a new value. Changes that land on the same edge produce a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, models power loss |
| link_rst | input | 1 | One-cycle link hardware-reset pulse |
| sysevt_upd | input | 1 | One-cycle pulse marking a decoded system-event update |
| warn_in | input | 3 | Warning levels: bit 0 host reset, bit 1 out-of-band reset, bit 2 suspend |
| plt_rst_in | input | 1 | Platform reset wire level from the master |
| out_wires | output | 5 | Outgoing wires: bit 0 boot done, bit 1 boot status, bits 2..4 acknowledges in `warn_in` order |
| out_strobe | output | 1 | High for one cycle when `out_wires` changes |
| oob_ready | output | 1 | Out-of-band channel-ready flag |
| plt_level | output | 1 | Recorded platform reset level |
| plt_valid | output | 1 | Platform reset level has been recorded |
| plt_chg | output | 1 | One-cycle pulse when the level is recorded |

## Verification
The assertions assume that every input is a level synchronous to `clk` and that `link_rst` and `sysevt_upd` are single-cycle pulses. They also assume `rst_n` is released only once, so no past-value check ever compares against a cycle that the reset overwrote. The stimulus changes every input on the falling edge, pulses the two strobes for exactly one cycle, and asserts reset only at the start. Warnings rise from a sampled low level, so each intended edge is visible to the edge detector.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
   // warning wire positions on warn_in
   localparam int NUM_WARN = 3;
   localparam int W_HOST   = 0;
   localparam int W_OOB    = 1;
   localparam int W_SUS    = 2;
   // outgoing wire positions on out_wires
   localparam int OUT_DONE = 0;
   localparam int OUT_STAT = 1;
   localparam int OUT_ACK0 = 2;
   localparam int OUT_W    = OUT_ACK0 + NUM_WARN;
   typedef logic [OUT_W-1:0] out_vec_t;
endpackage

// File: rtl/vwr_ack_chan.sv
// One warning/acknowledge pair: edge-triggered set, level-held, cleared on drop.
module vwr_ack_chan #(
   parameter bit BOOT_ASSIST = 1'b0,
   parameter bit LINK_CLEAR  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_rst,
   input  logic boot_run,
   input  logic warn,
   output logic ack
);
   logic warn_q;
   logic rise;
   logic assist;
   logic link_clr;

   assign rise     = warn & ~warn_q;
   assign assist   = boot_run & warn & BOOT_ASSIST;
   assign link_clr = link_rst & LINK_CLEAR;

   always_ff @(posedge clk) begin
      if (!rst_n) warn_q <= 1'b0;
      else        warn_q <= warn;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              ack <= 1'b0;
      else if (link_clr)       ack <= 1'b0;
      else if (!warn)          ack <= 1'b0;
      else if (rise || assist) ack <= 1'b1;
   end
endmodule

// File: rtl/vwr_boot_seq.sv
// Boot acknowledge pass after power-loss reset and after every link reset.
module vwr_boot_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic link_rst,
   output logic boot_run,
   output logic boot_done,
   output logic boot_status,
   output logic oob_ready
);
   always_ff @(posedge clk) begin
      if (!rst_n)        boot_run <= 1'b1;
      else if (link_rst) boot_run <= 1'b1;
      else               boot_run <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_done   <= 1'b0;
         boot_status <= 1'b0;
      end else if (boot_run && !boot_status) begin
         boot_done   <= 1'b1;
         boot_status <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        oob_ready <= 1'b0;
      else if (link_rst) oob_ready <= 1'b1;
   end
endmodule

// File: rtl/vwr_plt_track.sv
// Platform reset level tracker with unknown start state.
module vwr_plt_track (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic plt_in,
   output logic level,
   output logic valid,
   output logic chg
);
   logic plt_q;
   logic rec;

   assign rec = valid ? (plt_in != level) : (upd || (plt_in != plt_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plt_q <= 1'b0;
         level <= 1'b0;
         valid <= 1'b0;
         chg   <= 1'b0;
      end else begin
         plt_q <= plt_in;
         chg   <= rec;
         if (rec) begin
            level <= plt_in;
            valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/vwr_tx_merge.sv
// Shadow copy of the last sent vector; strobe flags any difference.
module vwr_tx_merge #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic         strobe
);
   logic [W-1:0] sent_q;

   assign strobe = (cur != sent_q);

   always_ff @(posedge clk) begin
      if (!rst_n) sent_q <= '0;
      else        sent_q <= cur;
   end
endmodule

// File: rtl/vw_sysevt_responder.sv
module vw_sysevt_responder
   import vwr_pkg::*;
#(
   parameter logic [NUM_WARN-1:0] BOOT_ASSIST_MASK    = 3'b100,
   parameter bit                  LINK_RST_CLEARS_ACK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                link_rst,
   input  logic                sysevt_upd,
   input  logic [NUM_WARN-1:0] warn_in,
   input  logic                plt_rst_in,
   output logic [OUT_W-1:0]    out_wires,
   output logic                out_strobe,
   output logic                oob_ready,
   output logic                plt_level,
   output logic                plt_valid,
   output logic                plt_chg
);
   localparam int ACK_HI = OUT_ACK0 + NUM_WARN - 1;

   if (NUM_WARN < 1) begin : g_bad_count
      $error("vw_sysevt_responder: at least one warning wire is needed");
   end
   if (OUT_W > 32) begin : g_bad_width
      $error("vw_sysevt_responder: outgoing vector wider than 32 bits");
   end

   logic                boot_run;
   logic                boot_done;
   logic                boot_status;
   logic [NUM_WARN-1:0] acks;
   out_vec_t            cur;

   vwr_boot_seq u_boot (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_rst    (link_rst),
      .boot_run    (boot_run),
      .boot_done   (boot_done),
      .boot_status (boot_status),
      .oob_ready   (oob_ready)
   );

   for (genvar i = 0; i < NUM_WARN; i++) begin : g_chan
      vwr_ack_chan #(
         .BOOT_ASSIST (BOOT_ASSIST_MASK[i]),
         .LINK_CLEAR  (LINK_RST_CLEARS_ACK)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .link_rst (link_rst),
         .boot_run (boot_run),
         .warn     (warn_in[i]),
         .ack      (acks[i])
      );
   end

   always_comb begin
      cur                  = '0;
      cur[OUT_DONE]        = boot_done;
      cur[OUT_STAT]        = boot_status;
      cur[ACK_HI:OUT_ACK0] = acks;
   end

   assign out_wires = cur;

   vwr_tx_merge #(.W(OUT_W)) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (cur),
      .strobe (out_strobe)
   );

   vwr_plt_track u_plt (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (sysevt_upd),
      .plt_in (plt_rst_in),
      .level  (plt_level),
      .valid  (plt_valid),
      .chg    (plt_chg)
   );
endmodule

// File: rtl/vwr_checker.sv
module vwr_checker
   import vwr_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                link_rst,
   input logic                sysevt_upd,
   input logic [NUM_WARN-1:0] warn_in,
   input logic                plt_rst_in,
   input logic [OUT_W-1:0]    out_wires,
   input logic                out_strobe,
   input logic                oob_ready,
   input logic                plt_level,
   input logic                plt_valid,
   input logic                plt_chg
);
   // R2: done and status move together
   p_boot_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_wires[OUT_STAT] == out_wires[OUT_DONE]);

   // R3: boot done never drops while out of reset
   p_boot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(out_wires[OUT_DONE])) |-> out_wires[OUT_DONE]);

   for (genvar i = 0; i < NUM_WARN; i++) begin : g_ack
      // R4, R5 and R6: acknowledge follows a warning rise
      p_ack_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (warn_in[i] && !$past(warn_in[i]) && !link_rst) |=> out_wires[OUT_ACK0+i]);
      // R7: acknowledge drops after its warning drops
      p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !warn_in[i] |=> !out_wires[OUT_ACK0+i]);
   end

   // R8: link reset raises the channel-ready flag
   p_oob_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(link_rst)) |-> oob_ready);

   // R9: a recorded level matches the sampled wire
   p_plt_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      plt_chg |-> (plt_valid && plt_level == $past(plt_rst_in)));

   // R9: first update makes the level valid
   p_plt_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!plt_valid && sysevt_upd) |=> plt_valid);

   // R10: every change of the vector is strobed
   p_strobe_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_wires != $past(out_wires)) |-> out_strobe);

   // R10: no strobe means no change
   p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !out_strobe) |-> $stable(out_wires));
endmodule

bind vw_sysevt_responder vwr_checker u_chk (.*);

// File: tb/vw_sysevt_responder_tb.sv
module vw_sysevt_responder_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       link_rst;
   logic       sysevt_upd;
   logic [2:0] warn_in;
   logic       plt_rst_in;
   logic [4:0] out_wires;
   logic       out_strobe;
   logic       oob_ready;
   logic       plt_level;
   logic       plt_valid;
   logic       plt_chg;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vw_sysevt_responder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_rst   (link_rst),
      .sysevt_upd (sysevt_upd),
      .warn_in    (warn_in),
      .plt_rst_in (plt_rst_in),
      .out_wires  (out_wires),
      .out_strobe (out_strobe),
      .oob_ready  (oob_ready),
      .plt_level  (plt_level),
      .plt_valid  (plt_valid),
      .plt_chg    (plt_chg)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state;
      rst_n = 1'b0; link_rst = 1'b0; sysevt_upd = 1'b0;
      warn_in = '0; plt_rst_in = 1'b0;
      step(3);
      chk("R1", "wires in reset", out_wires, 5'b00000);
      chk("R1", "strobe in reset", out_strobe, 1'b0);
      chk("R1", "oob_ready in reset", oob_ready, 1'b0);
      chk("R1", "plt_valid in reset", plt_valid, 1'b0);
      chk("R1", "plt_chg in reset", plt_chg, 1'b0);
   endtask

   task automatic t_boot_ack;
      rst_n = 1'b1;
      step(1);
      chk("R2", "boot wires after release", out_wires, 5'b00011);
      chk("R2", "boot strobe", out_strobe, 1'b1);
      step(1);
      chk("R10", "strobe one cycle", out_strobe, 1'b0);
      chk("R2", "boot wires held", out_wires, 5'b00011);
   endtask

   task automatic t_plt_track;
      step(2);
      chk("R9", "level invalid before update", plt_valid, 1'b0);
      sysevt_upd = 1'b1;
      step(1);
      sysevt_upd = 1'b0;
      chk("R9", "valid after update", plt_valid, 1'b1);
      chk("R9", "level after update", plt_level, 1'b0);
      chk("R9", "change pulse", plt_chg, 1'b1);
      step(1);
      chk("R9", "change pulse ends", plt_chg, 1'b0);
      plt_rst_in = 1'b1;
      step(1);
      chk("R9", "level follows change", plt_level, 1'b1);
      chk("R9", "change pulse on edge", plt_chg, 1'b1);
      step(1);
      chk("R9", "pulse ends after change", plt_chg, 1'b0);
   endtask

   task automatic t_host_ack;
      warn_in[0] = 1'b1;
      step(1);
      chk("R4", "host ack set", out_wires, 5'b00111);
      chk("R10", "strobe on host ack", out_strobe, 1'b1);
      step(3);
      chk("R7", "host ack held", out_wires[2], 1'b1);
      warn_in[0] = 1'b0;
      step(1);
      chk("R7", "host ack cleared", out_wires[2], 1'b0);
      chk("R10", "strobe on clear", out_strobe, 1'b1);
   endtask

   task automatic t_merge;
      int strobes = 0;
      warn_in[1:0] = 2'b11;
      step(1);
      chk("R5", "oob ack set", out_wires[3], 1'b1);
      chk("R10", "merged vector", out_wires, 5'b01111);
      for (int k = 0; k < 3; k++) begin
         if (out_strobe) strobes++;
         step(1);
      end
      chk("R10", "single merged strobe", strobes, 1);
      warn_in[1:0] = 2'b00;
      step(1);
      chk("R7", "both acks cleared", out_wires, 5'b00011);
   endtask

   task automatic t_sus_ack;
      warn_in[2] = 1'b1;
      step(1);
      chk("R6", "suspend ack set", out_wires[4], 1'b1);
      warn_in[0] = 1'b1;
      step(1);
      chk("R4", "host ack before link reset", out_wires, 5'b10111);
   endtask

   task automatic t_link_reset;
      link_rst = 1'b1;
      step(1);
      link_rst = 1'b0;
      chk("R8", "oob_ready set", oob_ready, 1'b1);
      chk("R8", "acks cleared by link reset", out_wires[4:2], 3'b000);
      chk("R3", "boot done kept", out_wires[1:0], 2'b11);
      step(1);
      chk("R8", "suspend ack by boot pass", out_wires[4], 1'b1);
      chk("R8", "host ack stays low", out_wires[2], 1'b0);
      step(3);
      chk("R8", "host ack still low", out_wires[2], 1'b0);
      chk("R3", "boot done still set", out_wires[0], 1'b1);
      warn_in[0] = 1'b0;
      step(1);
      warn_in[0] = 1'b1;
      step(1);
      chk("R4", "host ack after new rise", out_wires[2], 1'b1);
   endtask

   initial begin
      t_reset_state();
      t_boot_ack();
      t_plt_track();
      t_host_ack();
      t_merge();
      t_sus_ack();
      t_link_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule